// File: doc/BRIEF.md
# Multiplexed Receive Character Silo

This block is the receive side of a sixteen-line asynchronous serial multiplexer. Each line's deserialiser hands over a finished character, with its parity and framing error indications, through a one-cycle request. The block keeps that character in a small holding slot for the line, then moves one slot per cycle into a single shared first-in first-out store. Every stored entry is tagged with the number of the line it came from and with its error bits.

Software reads the receive data register to take the oldest entry out. Bit 15 of that register is set while an entry is being presented, so a loop that reads until the value stops being negative drains the silo. A control/status register holds the interrupt enables and flags and a master clear. A separate alarm register sets a fill level. Reaching that level raises a storage interrupt, and that interrupt stays independent of the plain "data waiting" receive interrupt.

Top module: `rx_silo_mux`

## Requirements
- R1: A read of the receive data register (bus address 1) presents the oldest entry as follows: bit 15 = 1, bit 14 = overrun, bit 13 = framing error, bit 12 = parity error, bits 11:8 = line number, bits 7:0 = character. When the silo is empty the read returns 0x0000.
- R2: Entries leave in the order they entered. Each read at address 1 of a non-empty silo removes exactly one entry at the clock edge.
- R3: Reading address 1 while the silo is empty changes nothing. The count stays zero and no entry or flag is created.
- R4: Each line has one holding slot that loads on a request. Each cycle the lowest-numbered occupied slot moves into the silo. A request on a line whose slot is occupied and not being drained that cycle is dropped, and the drop marks an overrun.
- R5: The silo holds 64 entries. If it is full at the clock edge, the character leaving a slot is dropped. The next entry that is stored then carries the overrun bit (bit 14).
- R6: Control/status register (bus address 0): bit 7 reads 1 while the silo holds data, bit 6 is the receive interrupt enable, bit 12 is the storage interrupt enable, and bit 14 is the storage flag. Writing sets bits 6 and 12.
- R7: The storage flag sets one cycle after the fill count first reaches a non-zero alarm level. It clears when the count is below the level. Writing 0 to bit 14 clears it, and it then stays clear until the count drops below the level and reaches it again.
- R8: irq = (bit 7 and bit 6) or (bit 14 and bit 12) of the control/status register.
- R9: The alarm register (bus address 2) takes its level from write bits 6:0 and reads it back in bits 6:0. A level of 0 never sets the storage flag. Address 3 reads 0.
- R10: Writing bit 11 = 1 to the control/status register is a master clear. It empties the silo and all holding slots, and clears any pending overrun, both enables, the storage flag and the alarm level. The other bits of that write are ignored.
- R11: After reset all registers read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_req | input | 16 | Per-line character-ready strobe |
| line_char | input | 128 | Per-line character, line i in bits 8i+7:8i |
| line_perr | input | 16 | Per-line parity error of the offered character |
| line_ferr | input | 16 | Per-line framing error of the offered character |
| bus_addr | input | 2 | Register select: 0 control/status, 1 receive data, 2 alarm |
| bus_rd | input | 1 | Read strobe; pops at address 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the full-silo drop: the overrun mark must land on the first entry stored after space opens up. This takes 64 stored entries with no reads, and each slot must be fed only when it is free, so that slot-level drops do not hide the full-level one. A directed phase feeds one line per cycle in rotation until the silo overflows, then pops a single entry and checks the overrun bit on the next arrival. Randomised phases with a bias toward pushing and then toward reading move the fill count back and forth across changing alarm levels. A reference queue checks every register read and irq in every cycle.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

  localparam int LINE_W = 4;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    SEL_CSR  = 2'd0,
    SEL_RXD  = 2'd1,
    SEL_ALM  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // control/status bit positions
  localparam int CSR_SFLAG = 14;
  localparam int CSR_SEN   = 12;
  localparam int CSR_MCLR  = 11;
  localparam int CSR_RFLAG = 7;
  localparam int CSR_REN   = 6;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

endpackage

// File: rtl/rx_silo_arb.sv
module rx_silo_arb
  import rx_silo_pkg::*;
#(
  parameter int NLINES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mclr,
  input  logic [NLINES-1:0]        line_req,
  input  logic [NLINES*CHAR_W-1:0] line_char,
  input  logic [NLINES-1:0]        line_perr,
  input  logic [NLINES-1:0]        line_ferr,
  input  logic                     silo_full,
  output logic                     push,
  output entry_t                   push_entry
);

  logic [NLINES-1:0]             slot_vld_q, slot_vld_d;
  logic [NLINES-1:0][CHAR_W-1:0] slot_ch_q, slot_ch_d;
  logic [NLINES-1:0]             slot_pe_q, slot_pe_d;
  logic [NLINES-1:0]             slot_fe_q, slot_fe_d;
  logic                          ovr_q, ovr_d;

  logic              win_vld;
  logic [LINE_W-1:0] win_idx;
  logic [NLINES-1:0] slot_drop;
  logic [NLINES-1:0] slot_ld;

  // lowest-numbered occupied slot wins
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (slot_vld_q[i]) begin
        win_vld = 1'b1;
        win_idx = LINE_W'(i);
      end
    end
  end

  assign push = win_vld && !silo_full;

  always_comb begin
    push_entry      = '0;
    push_entry.ovr  = ovr_q;
    push_entry.ferr = slot_fe_q[win_idx];
    push_entry.perr = slot_pe_q[win_idx];
    push_entry.line = win_idx;
    push_entry.ch   = slot_ch_q[win_idx];
  end

  generate
    for (genvar g = 0; g < NLINES; g++) begin : g_slot
      logic keeps;
      assign keeps        = slot_vld_q[g] && !(win_vld && (win_idx == LINE_W'(g)));
      assign slot_ld[g]   = line_req[g] && !keeps && !mclr;
      assign slot_drop[g] = line_req[g] && keeps;

      always_comb begin
        slot_ch_d[g] = slot_ch_q[g];
        slot_pe_d[g] = slot_pe_q[g];
        slot_fe_d[g] = slot_fe_q[g];
        if (mclr) begin
          slot_vld_d[g] = 1'b0;
        end else if (slot_ld[g]) begin
          slot_vld_d[g] = 1'b1;
          slot_ch_d[g]  = line_char[g*CHAR_W +: CHAR_W];
          slot_pe_d[g]  = line_perr[g];
          slot_fe_d[g]  = line_ferr[g];
        end else begin
          slot_vld_d[g] = keeps;
        end
      end
    end
  endgenerate

  always_comb begin
    if (mclr) begin
      ovr_d = 1'b0;
    end else begin
      ovr_d = (ovr_q && !push) || (win_vld && silo_full) || (|slot_drop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld_q <= '0;
      ovr_q      <= 1'b0;
    end else begin
      slot_vld_q <= slot_vld_d;
      ovr_q      <= ovr_d;
    end
  end

  // payload registers carry no reset; the valid bit qualifies them
  always_ff @(posedge clk) begin
    for (int i = 0; i < NLINES; i++) begin
      if (slot_ld[i]) begin
        slot_ch_q[i] <= slot_ch_d[i];
        slot_pe_q[i] <= slot_pe_d[i];
        slot_fe_q[i] <= slot_fe_d[i];
      end
    end
  end

endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              push,
  input  logic [WIDTH-1:0]  push_data,
  input  logic              pop,
  output logic [WIDTH-1:0]  head,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic              full,
  output logic              empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !mclr;
  assign do_pop  = pop && !empty && !mclr;
  assign head    = mem_q[rd_ptr_q];
  assign fill    = cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (mclr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = bump(wr_ptr_q);
      if (do_pop)  rd_ptr_d = bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data;
  end

endmodule

// File: rtl/rx_silo_ctrl.sv
module rx_silo_ctrl
  import rx_silo_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic             alm_we,
  input  logic [15:0]      wdata,
  input  logic [CNT_W-1:0] fill,
  output logic             mclr,
  output logic             ren,
  output logic             sen,
  output logic             sflag,
  output logic [CNT_W-1:0] level
);

  logic             ren_q, ren_d;
  logic             sen_q, sen_d;
  logic             sflag_q, sflag_d;
  logic             above_q, above_d;
  logic [CNT_W-1:0] level_q, level_d;

  assign mclr    = csr_we && wdata[CSR_MCLR];
  assign above_d = (level_q != '0) && (fill >= level_q);

  always_comb begin
    ren_d   = ren_q;
    sen_d   = sen_q;
    level_d = level_q;
    sflag_d = sflag_q;
    if (mclr) begin
      ren_d   = 1'b0;
      sen_d   = 1'b0;
      level_d = '0;
      sflag_d = 1'b0;
    end else begin
      if (csr_we) begin
        ren_d = wdata[CSR_REN];
        sen_d = wdata[CSR_SEN];
      end
      if (alm_we) level_d = wdata[CNT_W-1:0];
      if (!above_d) begin
        sflag_d = 1'b0;
      end else if (!above_q) begin
        sflag_d = 1'b1;
      end else if (csr_we && !wdata[CSR_SFLAG]) begin
        sflag_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ren_q   <= 1'b0;
      sen_q   <= 1'b0;
      sflag_q <= 1'b0;
      above_q <= 1'b0;
      level_q <= '0;
    end else begin
      ren_q   <= ren_d;
      sen_q   <= sen_d;
      sflag_q <= sflag_d;
      above_q <= mclr ? 1'b0 : above_d;
      level_q <= level_d;
    end
  end

  assign ren   = ren_q;
  assign sen   = sen_q;
  assign sflag = sflag_q;
  assign level = level_q;

endmodule

// File: rtl/rx_silo_mux.sv
module rx_silo_mux
  import rx_silo_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int DEPTH  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLINES-1:0]        line_req,
  input  logic [NLINES*CHAR_W-1:0] line_char,
  input  logic [NLINES-1:0]        line_perr,
  input  logic [NLINES-1:0]        line_ferr,
  input  logic [1:0]               bus_addr,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [15:0]              bus_wdata,
  output logic [15:0]              bus_rdata,
  output logic                     irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  reg_sel_e         sel;
  logic             mclr;
  logic             push;
  entry_t           push_entry;
  logic [ENTRY_W-1:0] head;
  logic [CNT_W-1:0] fill_cnt;
  logic             full, empty;
  logic             ren, sen, sflag;
  logic [CNT_W-1:0] level;
  logic             pop;
  logic             rflag;

  assign sel   = reg_sel_e'(bus_addr);
  assign pop   = bus_rd && (sel == SEL_RXD);
  assign rflag = !empty;

  rx_silo_arb #(.NLINES(NLINES)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .mclr       (mclr),
    .line_req   (line_req),
    .line_char  (line_char),
    .line_perr  (line_perr),
    .line_ferr  (line_ferr),
    .silo_full  (full),
    .push       (push),
    .push_entry (push_entry)
  );

  rx_silo_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclr      (mclr),
    .push      (push),
    .push_data (push_entry),
    .pop       (pop),
    .head      (head),
    .fill      (fill_cnt),
    .full      (full),
    .empty     (empty)
  );

  rx_silo_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .csr_we (bus_wr && (sel == SEL_CSR)),
    .alm_we (bus_wr && (sel == SEL_ALM)),
    .wdata  (bus_wdata),
    .fill   (fill_cnt),
    .mclr   (mclr),
    .ren    (ren),
    .sen    (sen),
    .sflag  (sflag),
    .level  (level)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CSR: begin
        bus_rdata[CSR_SFLAG] = sflag;
        bus_rdata[CSR_SEN]   = sen;
        bus_rdata[CSR_RFLAG] = rflag;
        bus_rdata[CSR_REN]   = ren;
      end
      SEL_RXD: bus_rdata = empty ? 16'h0000 : {1'b1, head};
      SEL_ALM: bus_rdata = 16'(level);
      default: bus_rdata = '0;
    endcase
  end

  assign irq = (rflag && ren) || (sflag && sen);

endmodule

// File: rtl/rx_silo_mux_chk.sv
module rx_silo_mux_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [15:0]      bus_wdata,
  input logic [15:0]      bus_rdata,
  input logic             irq,
  input logic [CNT_W-1:0] fill_cnt,
  input logic [CNT_W-1:0] level,
  input logic             sflag,
  input logic             ren,
  input logic             sen,
  input logic             push
);

  logic clr_req;
  assign clr_req = bus_wr && (bus_addr == 2'd0) && bus_wdata[11];

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(DEPTH));

  // R1
  valid_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> (bus_rdata[15] == (fill_cnt != '0)));

  // R3
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1 && fill_cnt == '0 && !push && !clr_req) |=> (fill_cnt == '0));

  // R2
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1 && fill_cnt != '0 && !push && !clr_req)
      |=> (fill_cnt == $past(fill_cnt) - 1'b1));

  // R7
  sflag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sflag) |-> $past(level != '0 && fill_cnt >= level));

  // R10
  mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (fill_cnt == '0 && level == '0 && !ren && !sen && !sflag));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren && !sen) |-> !irq);

endmodule

bind rx_silo_mux rx_silo_mux_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .fill_cnt  (fill_cnt),
  .level     (level),
  .sflag     (sflag),
  .ren       (ren),
  .sen       (sen),
  .push      (push)
);

// File: tb/rx_silo_mux_tb_top.sv
module rx_silo_mux_tb_top;

  localparam int NL = 16;
  localparam int DP = 64;

  logic          clk;
  logic          rst_n;
  logic [NL-1:0] line_req;
  logic [NL*8-1:0] line_char;
  logic [NL-1:0] line_perr;
  logic [NL-1:0] line_ferr;
  logic [1:0]    bus_addr;
  logic          bus_rd;
  logic          bus_wr;
  logic [15:0]   bus_wdata;
  logic [15:0]   bus_rdata;
  logic          irq;

  int n_chk;
  int n_bad;
  bit done;

  rx_silo_mux #(.NLINES(NL), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_req(line_req), .line_char(line_char),
    .line_perr(line_perr), .line_ferr(line_ferr), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference model state
  logic [14:0] mq[$];
  bit   sv[NL];
  bit [7:0] sch[NL];
  bit   spe[NL];
  bit   sfe[NL];
  bit   movr;
  int   mlvl;
  bit   mren, msen, msfl, mabove;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      for (int i = 0; i < NL; i++) sv[i] = 0;
      movr = 0; mlvl = 0; mren = 0; msen = 0; msfl = 0; mabove = 0;
    end else if (bus_wr && bus_addr == 2'd0 && bus_wdata[11]) begin
      mq.delete();
      for (int i = 0; i < NL; i++) sv[i] = 0;
      movr = 0; mlvl = 0; mren = 0; msen = 0; msfl = 0; mabove = 0;
    end else begin
      int  cnt;
      int  win;
      bit  abv;
      bit  pushed;
      bit  drop;
      cnt = mq.size();
      abv = (mlvl != 0) && (cnt >= mlvl);
      if (!abv) msfl = 0;
      else if (!mabove) msfl = 1;
      else if (bus_wr && bus_addr == 2'd0 && !bus_wdata[14]) msfl = 0;
      mabove = abv;
      if (bus_wr && bus_addr == 2'd0) begin
        mren = bus_wdata[6];
        msen = bus_wdata[12];
      end
      if (bus_wr && bus_addr == 2'd2) mlvl = int'(bus_wdata[6:0]);
      win = -1;
      for (int i = 0; i < NL; i++) if (sv[i] && win < 0) win = i;
      pushed = 0;
      drop = 0;
      if (bus_rd && bus_addr == 2'd1 && cnt > 0) void'(mq.pop_front());
      if (win >= 0) begin
        if (cnt < DP) begin
          mq.push_back({movr, sfe[win], spe[win], 4'(win), sch[win]});
          pushed = 1;
        end else begin
          drop = 1;
        end
        sv[win] = 0;
      end
      for (int i = 0; i < NL; i++) begin
        if (line_req[i]) begin
          if (sv[i]) drop = 1;
          else begin
            sv[i] = 1; sch[i] = line_char[i*8 +: 8];
            spe[i] = line_perr[i]; sfe[i] = line_ferr[i];
          end
        end
      end
      movr = (movr && !pushed) || drop;
    end
  end

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    logic [15:0] v;
    v = '0;
    case (a)
      2'd0: begin
        v[14] = msfl; v[12] = msen; v[7] = (mq.size() != 0); v[6] = mren;
      end
      2'd1: v = (mq.size() != 0) ? {1'b1, mq[0]} : 16'h0000;
      2'd2: v = 16'(mlvl);
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic exp_irq();
    return ((mq.size() != 0) && mren) || (msfl && msen);
  endfunction

  task automatic compare(input string tag);
    logic [15:0] e;
    logic ei;
    e  = exp_rd(bus_addr);
    ei = exp_irq();
    n_chk++;
    if (bus_rdata !== e) begin
      n_bad++;
      $display("FAIL %s addr=%0d rdata actual=%h expected=%h", tag, bus_addr, bus_rdata, e);
    end
    n_chk++;
    if (irq !== ei) begin
      n_bad++;
      $display("FAIL R8 (%s) irq actual=%b expected=%b", tag, irq, ei);
    end
  endtask

  // one bus/line cycle: drive after the falling edge, check, wait for next fall
  task automatic cyc(input logic [NL-1:0] rq, input logic [NL*8-1:0] ch,
                     input logic [NL-1:0] pe, input logic [NL-1:0] fe,
                     input logic rd, input logic wr, input logic [1:0] a,
                     input logic [15:0] wd, input string tag);
    line_req = rq; line_char = ch; line_perr = pe; line_ferr = fe;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic idle_read(input logic [1:0] a, input string tag);
    cyc('0, '0, '0, '0, 1'b0, 1'b0, a, 16'h0, tag);
  endtask

  task automatic rnd_cycles(input int n, input int p_req, input int p_rd, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [NL-1:0] rq, pe, fe;
      logic [NL*8-1:0] ch;
      logic rd, wr;
      logic [1:0] a;
      logic [15:0] wd;
      for (int i = 0; i < NL; i++) begin
        rq[i] = ($urandom_range(0, 999) < p_req);
        pe[i] = ($urandom_range(0, 9) == 0);
        fe[i] = ($urandom_range(0, 11) == 0);
        ch[i*8 +: 8] = 8'($urandom);
      end
      rd = ($urandom_range(0, 99) < p_rd);
      a  = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd1;
      wr = 1'b0;
      wd = 16'($urandom);
      wd[11] = ($urandom_range(0, 999) == 0);
      if ($urandom_range(0, 39) == 0) begin wr = 1'b1; rd = 1'b0; a = 2'd0; end
      else if ($urandom_range(0, 79) == 0) begin
        wr = 1'b1; rd = 1'b0; a = 2'd2; wd = 16'($urandom_range(0, 70));
      end
      cyc(rq, ch, pe, fe, rd, wr, a, wd, tag);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    line_req = '0; line_char = '0; line_perr = '0; line_ferr = '0;
    bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state of every register
    for (int a = 0; a < 4; a++) idle_read(2'(a), "R11");

    // R3 reads of an empty silo, then a single char must arrive with no overrun
    for (int k = 0; k < 4; k++) cyc('0, '0, '0, '0, 1'b1, 1'b0, 2'd1, 16'h0, "R3");
    cyc(16'h0020, {NL{8'h5a}}, '0, '0, 1'b0, 1'b0, 2'd1, 16'h0, "R3");
    idle_read(2'd1, "R3");
    idle_read(2'd1, "R3");
    cyc('0, '0, '0, '0, 1'b1, 1'b0, 2'd1, 16'h0, "R1");
    idle_read(2'd1, "R1");

    // R4 all lines at once: priority order, then collision on busy slots
    begin
      logic [NL*8-1:0] ch;
      for (int i = 0; i < NL; i++) ch[i*8 +: 8] = 8'(8'h30 + i);
      cyc(16'hffff, ch, 16'h00f0, 16'h0f00, 1'b0, 1'b0, 2'd1, 16'h0, "R4");
      cyc(16'h8001, ~ch, '0, '0, 1'b0, 1'b0, 2'd1, 16'h0, "R4");
      for (int k = 0; k < 20; k++) idle_read(2'd0, "R4");
      for (int k = 0; k < 18; k++) cyc('0, '0, '0, '0, 1'b1, 1'b0, 2'd1, 16'h0, "R4");
    end

    // R6 / R9 enables, alarm level, readbacks
    cyc('0, '0, '0, '0, 1'b0, 1'b1, 2'd0, 16'h1040, "R6");
    idle_read(2'd0, "R6");
    cyc('0, '0, '0, '0, 1'b0, 1'b1, 2'd2, 16'h0010, "R9");
    idle_read(2'd2, "R9");

    // R5 fill past 64 feeding one free slot per cycle, then pop and refill
    for (int k = 0; k < 72; k++) begin
      logic [NL-1:0] rq;
      rq = '0; rq[k % NL] = 1'b1;
      cyc(rq, {NL{8'(k)}}, '0, '0, 1'b0, 1'b0, 2'd0, 16'h0, "R5");
    end
    idle_read(2'd0, "R7");
    cyc('0, '0, '0, '0, 1'b1, 1'b0, 2'd1, 16'h0, "R5");
    cyc(16'h0004, {NL{8'hc3}}, '0, '0, 1'b0, 1'b0, 2'd0, 16'h0, "R5");
    for (int k = 0; k < 3; k++) idle_read(2'd0, "R5");

    // R7 software clear of the storage flag while still above level
    cyc('0, '0, '0, '0, 1'b0, 1'b1, 2'd0, 16'h1040, "R7");
    for (int k = 0; k < 3; k++) idle_read(2'd0, "R7");
    for (int k = 0; k < 70; k++) cyc('0, '0, '0, '0, 1'b1, 1'b0, 2'd1, 16'h0, "R2");
    for (int k = 0; k < 3; k++) idle_read(2'd0, "R7");

    // random phases, push-biased then read-biased
    rnd_cycles(4000, 120, 10, "R2");
    rnd_cycles(4000, 30, 70, "R2");
    rnd_cycles(4000, 60, 40, "R7");

    // R10 master clear with data and enables present
    cyc(16'h00ff, {NL{8'h11}}, '0, '0, 1'b0, 1'b1, 2'd2, 16'h0004, "R10");
    for (int k = 0; k < 4; k++) idle_read(2'd0, "R10");
    cyc(16'h0f00, {NL{8'h22}}, '0, '0, 1'b0, 1'b1, 2'd0, 16'h5840, "R10");
    for (int a = 0; a < 4; a++) idle_read(2'd0 + 2'(a), "R10");
    for (int k = 0; k < 4; k++) idle_read(2'd1, "R10");

    rnd_cycles(3000, 80, 50, "R4");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule